// File: doc/BRIEF.md
# Masked AES SubBytes Unit with Mask Conversion

This block computes the AES byte substitution on a value that is never present in the clear. The caller supplies the data byte already hidden under an additive (XOR) mask, the mask itself, and a second, nonzero multiplicative mask. Inside, the additive mask is first traded for the multiplicative one. The product is then inverted in GF(2^8) by an ordinary inverter that has no knowledge of masking. Next the additive mask is restored, and finally the affine map is applied to both the masked data and the mask, so the caller receives a masked result together with the mask that now covers it.

A one-cycle `start` pulse loads the three input bytes. The unit then steps through four internal operations, one per clock, and pulses `done` when the masked result and its new mask are ready. Both outputs then hold until the next accepted start. Arithmetic uses the field polynomial x^8 + x^4 + x^3 + x + 1. The inverse of the multiplicative mask is computed internally.

Top module: `masked_sbox`

## Requirements
- R1: While `rstN` is low and after it is released, `busy` and `done` are 0 and `outData` and `outMask` are 0x00.
- R2: A `start` seen high at a rising edge while `busy` is 0 loads the inputs. `done` is then high for exactly one cycle, after the fifth rising edge counted from the loading edge, and `busy` is high from the loading edge until that fifth edge.
- R3: For any data byte A, additive mask X and nonzero multiplicative mask Y, with `maskedIn` = A xor X, the result satisfies `outData` xor `outMask` = S(A). S is the AES S-box: the inverse in GF(2^8) modulo 0x11B (with 0 mapped to 0), followed by the affine map.
- R4: `outMask` equals the linear part of the affine map applied to X, without the constant 0x63. Bit i of that map is x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8]. The constant 0x63 is added to the data path only, so X = 0 gives `outMask` = 0 and `outData` = S(A).
- R5: A data byte A = 0x00 yields `outData` xor `outMask` = 0x63 for any X and nonzero Y.
- R6: A `start` pulse that arrives while `busy` is 1 is ignored. The running operation completes with its original inputs, and no extra `done` pulse follows.
- R7: After `done`, `outData` and `outMask` hold their values until the next accepted `start`.
- R8: The result does not depend on the value of the nonzero multiplicative mask Y. Its inverse is formed inside the block, and Y = 0 is not a supported input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request, accepted only while idle |
| maskedIn | input | 8 | Data byte xor additive mask |
| maskAdd | input | 8 | Additive mask X |
| maskMul | input | 8 | Multiplicative mask Y, nonzero |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle pulse when the result is ready |
| outData | output | 8 | Masked substitution result |
| outMask | output | 8 | New additive mask covering outData |

## Verification
The case that is hardest to reach from the ports is a start request arriving mid-operation with different operands. The stimulus raises `start` with fresh bytes two cycles after a load and then confirms that the result belongs to the first operands and that only one `done` appears. The zero data byte and the zero additive mask are also driven directly, because random bytes seldom produce them. The same A and X are run under the multiplicative masks 0x01 and 0xFF to show that Y leaves no trace in the result.

// File: rtl/msbox_pkg.sv
package msbox_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;
  localparam logic [BYTE_W:0] FIELD_POLY = 9'h11B;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic load;
    logic toMul;
    logic invert;
    logic toAdd;
    logic affine;
  } strobe_t;

  function automatic byte_t gfMul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ((sh << 1) ^ FIELD_POLY[BYTE_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic byte_t gfSq(byte_t a);
    return gfMul(a, a);
  endfunction

  function automatic byte_t affLin(byte_t v);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = v[i] ^ v[(i+4)%BYTE_W] ^ v[(i+5)%BYTE_W] ^ v[(i+6)%BYTE_W] ^ v[(i+7)%BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/gf_inverter.sv
module gf_inverter
  import msbox_pkg::*;
(
  input  logic [BYTE_W-1:0] opIn,
  output logic [BYTE_W-1:0] opInv
);
  byte_t p3, p7, p15, p31, p63, p127;

  always_comb begin
    p3    = gfMul(gfSq(opIn), opIn);
    p7    = gfMul(gfSq(p3), opIn);
    p15   = gfMul(gfSq(p7), opIn);
    p31   = gfMul(gfSq(p15), opIn);
    p63   = gfMul(gfSq(p31), opIn);
    p127  = gfMul(gfSq(p63), opIn);
    opInv = gfSq(p127);
  end
endmodule

// File: rtl/msbox_ctrl.sv
module msbox_ctrl
  import msbox_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {ST_IDLE, ST_MUL, ST_INV, ST_ADD, ST_AFF} state_t;
  state_t state, stateNxt;

  always_comb begin
    stb        = '0;
    stb.load   = start && (state == ST_IDLE);
    stb.toMul  = (state == ST_MUL);
    stb.invert = (state == ST_INV);
    stb.toAdd  = (state == ST_ADD);
    stb.affine = (state == ST_AFF);
    unique case (state)
      ST_IDLE: stateNxt = start ? ST_MUL : ST_IDLE;
      ST_MUL:  stateNxt = ST_INV;
      ST_INV:  stateNxt = ST_ADD;
      ST_ADD:  stateNxt = ST_AFF;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_AFF);
    end
  end

  assign busy = (state != ST_IDLE);

  // R2: result strobe is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: the affine step is followed by done
  p_aff_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.affine |=> done);
  // R6: a start while busy does not cut the sequence short
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.affine) |=> busy);
endmodule

// File: rtl/msbox_dp.sv
module msbox_dp
  import msbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] maskedIn,
  input  logic [BYTE_W-1:0] maskAdd,
  input  logic [BYTE_W-1:0] maskMul,
  output logic [BYTE_W-1:0] outData,
  output logic [BYTE_W-1:0] outMask
);
  byte_t dataReg, xReg, yReg, yInvReg;
  byte_t dataInv, yInvC;

  // same inverter structure for the masked product and for the mask Y
  gf_inverter i_invData (.opIn(dataReg), .opInv(dataInv));
  gf_inverter i_invMask (.opIn(yReg),    .opInv(yInvC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      xReg    <= '0;
      yReg    <= '0;
      yInvReg <= '0;
    end else begin
      if (stb.load) begin
        dataReg <= maskedIn;
        xReg    <= maskAdd;
        yReg    <= maskMul;
      end
      if (stb.toMul) begin
        // (A^X)*Y ^ X*Y = A*Y
        dataReg <= gfMul(dataReg, yReg) ^ gfMul(xReg, yReg);
        yInvReg <= yInvC;
      end
      if (stb.invert) dataReg <= dataInv;
      if (stb.toAdd)  dataReg <= gfMul(dataReg ^ gfMul(xReg, yInvReg), yReg);
      if (stb.affine) begin
        dataReg <= affLin(dataReg) ^ AFF_CONST;
        xReg    <= affLin(xReg);
      end
    end
  end

  assign outData = dataReg;
  assign outMask = xReg;

  // R8: the multiplicative mask is nonzero when it is used
  p_y_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.toMul |-> (yReg != '0));
  // R8: the internal inverse of Y is correct by the time it is needed
  p_yinv_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.toAdd |-> (gfMul(yReg, yInvReg) == 8'h01));
  // R7: the output mask moves only on load or on the affine step
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load || stb.affine) |=> $stable(xReg));
  // R7: the data output holds while idle without a load
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load || stb.toMul || stb.invert || stb.toAdd || stb.affine) |=> $stable(dataReg));
endmodule

// File: rtl/masked_sbox.sv
module masked_sbox
  import msbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] maskedIn,
  input  logic [BYTE_W-1:0] maskAdd,
  input  logic [BYTE_W-1:0] maskMul,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] outData,
  output logic [BYTE_W-1:0] outMask
);
  strobe_t stb;

  msbox_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .busy(busy), .done(done)
  );

  msbox_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .maskedIn(maskedIn), .maskAdd(maskAdd), .maskMul(maskMul),
    .outData(outData), .outMask(outMask)
  );

  // R1: nothing is reported done while idle after reset without a load
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done && !start) |=> !done);
endmodule

// File: tb/test_masked_sbox.sv
module test_masked_sbox;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] maskedIn = '0, maskAdd = '0, maskMul = 8'h01;
  logic busy, done;
  logic [7:0] outData, outMask;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  masked_sbox i_masked_sbox (
    .clk(clk), .rstN(rstN), .start(start),
    .maskedIn(maskedIn), .maskAdd(maskAdd), .maskMul(maskMul),
    .busy(busy), .done(done), .outData(outData), .outMask(outMask)
  );

  // independent reference: shift-and-add multiply, inverse by search, rotate-form affine
  function automatic logic [7:0] refMul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] refInv(logic [7:0] a);
    logic [7:0] r = '0;
    for (int c = 1; c < 256; c++) if (refMul(a, 8'(c)) == 8'h01) r = 8'(c);
    return r;
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] refLin(logic [7:0] v);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4);
  endfunction

  function automatic logic [7:0] refSbox(logic [7:0] a);
    return refLin(refInv(a)) ^ 8'h63;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [7:0] a, input logic [7:0] x, input logic [7:0] y,
                       output logic [7:0] d, output logic [7:0] m, output int lat);
    @(negedge clk);
    maskedIn = a ^ x; maskAdd = x; maskMul = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    d = outData; m = outMask;
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 outData", 32'(outData), 0);
    check("R1 outMask", 32'(outMask), 0);
  endtask

  task automatic t_known;
    logic [7:0] d, m; int lat;
    runOp(8'h53, 8'hA5, 8'h37, d, m, lat);
    check("R2 latency", 32'(lat), 5);
    check("R3 S(53)", 32'(d ^ m), 32'h ED);
    check("R4 mask", 32'(m), 32'(refLin(8'hA5)));
    @(negedge clk);
    check("R2 done pulse width", 32'(done), 0);
    check("R2 busy after", 32'(busy), 0);
  endtask

  task automatic t_random;
    logic [7:0] d, m, a, x, y; int lat;
    for (int k = 0; k < 40; k++) begin
      a = 8'($urandom); x = 8'($urandom); y = 8'($urandom % 255 + 1);
      runOp(a, x, y, d, m, lat);
      check("R3 random unmask", 32'(d ^ m), 32'(refSbox(a)));
      check("R4 random mask", 32'(m), 32'(refLin(x)));
    end
  endtask

  task automatic t_zero;
    logic [7:0] d, m; int lat;
    runOp(8'h00, 8'h9C, 8'h11, d, m, lat);
    check("R5 zero data", 32'(d ^ m), 32'h63);
    runOp(8'h01, 8'h00, 8'hC2, d, m, lat);
    check("R4 zero mask data", 32'(d), 32'h7C);
    check("R4 zero mask", 32'(m), 0);
  endtask

  task automatic t_y_indep;
    logic [7:0] d1, m1, d2, m2; int lat;
    runOp(8'h3A, 8'h5E, 8'h01, d1, m1, lat);
    runOp(8'h3A, 8'h5E, 8'hFF, d2, m2, lat);
    check("R8 data same across Y", 32'(d2), 32'(d1));
    check("R8 mask same across Y", 32'(m2), 32'(m1));
    check("R8 value", 32'(d2 ^ m2), 32'(refSbox(8'h3A)));
  endtask

  task automatic t_busy_ignore;
    int lat; int dones;
    @(negedge clk);
    maskedIn = 8'hC0 ^ 8'h12; maskAdd = 8'h12; maskMul = 8'h45; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    maskedIn = 8'hFF; maskAdd = 8'h77; maskMul = 8'h09; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check("R6 latency kept", 32'(lat), 5);
    check("R6 first operands", 32'(outData ^ outMask), 32'(refSbox(8'hC0)));
    check("R6 first mask", 32'(outMask), 32'(refLin(8'h12)));
    dones = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R6 no extra done", 32'(dones), 0);
  endtask

  task automatic t_hold;
    logic [7:0] d, m; int lat;
    runOp(8'hB7, 8'h2D, 8'h80, d, m, lat);
    maskedIn = 8'h00; maskAdd = 8'hFF; maskMul = 8'h03;
    repeat (4) @(negedge clk);
    check("R7 data hold", 32'(outData), 32'(d));
    check("R7 mask hold", 32'(outMask), 32'(m));
    check("R7 idle", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_random();
    t_zero();
    t_y_indep();
    t_busy_ignore();
    t_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule